// File: doc/BRIEF.md
# Raster-Operation Rectangle Blit Engine

This block moves or paints a rectangle of pixels inside a linear, byte-addressed memory. A command gives a destination base, pitch and two corners, and a source base, pitch and origin. It also gives an 8-bit raster-operation code, a pixel depth of 1, 2 or 4 bytes, a fill colour and two write enables for 4-byte pixels. Each written pixel is a bitwise function of three operands: the fill colour (P), the source pixel (S) and the current destination pixel (D). The raster code is the truth table of that function.

The engine walks the destination rectangle row by row. For each pixel it fetches only the operands that the raster code depends on, then writes the result through a single-beat memory port with byte strobes. A signed source pitch lets the source rows run downward in memory, which mirrors the image vertically. The host starts a command with a one-cycle `start` when `busy` is low. It sees completion as a one-cycle `done`.

Top module: `blt_engine`

## Requirements
- R1: Each result bit at position i equals rop[{P[i],S[i],D[i]}]. With this encoding, 0xCC copies the source, 0xF0 paints the fill colour, 0xAA leaves the destination unchanged, 0x00 clears, 0xFF sets, 0x66 is S xor D and 0x55 inverts D.
- R2: The destination rectangle spans x1 ≤ x < x2 and y1 ≤ y < y2, with corners compared as signed 16-bit values. When x2 ≤ x1 or y2 ≤ y1 the command writes nothing and still produces one done pulse.
- R3: A pixel's byte address is base + y·pitch + x·bytes, with the pitch taken as signed 16 bits and its two low bits treated as zero. The memory port carries the word address (byte address >> 2). Byte lane k of the 32-bit word holds byte address 4·word + k.
- R4: A negative source pitch reads successive destination rows from source rows that lie lower in memory, which flips the copy vertically.
- R5: The depth code selects 1, 2 or 4 bytes per pixel for codes 0, 1 and 2. Code 3 makes the command write nothing, like an empty rectangle. A 1-byte pixel write asserts exactly one strobe.
- R6: For 4-byte pixels, strobe lane 3 (the alpha byte) follows the alpha enable and lanes 2..0 follow the colour enable. For 1- and 2-byte pixels both enables are ignored and every byte of the pixel is written.
- R7: The source is read once per pixel only when the raster code depends on S. The destination is read once per pixel only when it depends on D. Each pixel is written exactly once.
- R8: Pixels are written from left to right within a row, and rows from top to bottom, in destination order.
- R9: A command is accepted only while busy is low, including the cycle in which done is high. A start while busy is ignored. Once the command completes, busy falls in the same cycle as the single one-cycle done pulse.
- R10: A memory request keeps its address and direction unchanged until the cycle in which it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command strobe, taken when busy is low |
| dst_base | input | 16 | Destination base byte address |
| dst_pitch | input | 16 | Destination row pitch in bytes, signed |
| dst_x1 | input | 16 | Left edge, inclusive, signed |
| dst_y1 | input | 16 | Top edge, inclusive, signed |
| dst_x2 | input | 16 | Right edge, exclusive, signed |
| dst_y2 | input | 16 | Bottom edge, exclusive, signed |
| src_base | input | 16 | Source base byte address |
| src_pitch | input | 16 | Source row pitch in bytes, signed |
| src_x | input | 16 | Source origin column, signed |
| src_y | input | 16 | Source origin row, signed |
| rop | input | 8 | Raster-operation truth table |
| depth | input | 2 | Pixel size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| fill_color | input | 32 | Fill colour (P operand), low bytes used |
| alpha_en | input | 1 | Write enable for byte 3 of 4-byte pixels |
| rgb_en | input | 1 | Write enable for bytes 2..0 of 4-byte pixels |
| busy | output | 1 | A command is being executed |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 14 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte write strobes |
| mem_ack | input | 1 | Memory accepts the request in this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The completion of one command and the acceptance of the next can happen in the same cycle, because start is honoured while done is high. The bench provokes this by raising start in the very cycle it sees done. It judges the result by the final memory image, which must equal both commands applied in order, and by a count of exactly two done pulses. The opposite collision is a start raised in the middle of a walk. There the image must show only the first command, and only one done pulse may appear. Memory acknowledges are stalled at random, so the last write's acknowledge also lands in various positions relative to these starts.

// File: rtl/blt_pkg.sv
// Shared types and helpers for the raster-op blit engine.
// Assumes an 8-bit raster code indexed as {P,S,D}.
package blt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRD,
        ST_DRD,
        ST_WR,
        ST_DONE
    } blt_state_e;

    localparam logic [1:0] DEPTH_1B = 2'd0;
    localparam logic [1:0] DEPTH_2B = 2'd1;
    localparam logic [1:0] DEPTH_4B = 2'd2;

    // True when flipping the S index bit changes some entry of the table.
    function automatic logic rop_uses_src(input logic [7:0] code);
        return (code & 8'h33) != ((code >> 2) & 8'h33);
    endfunction

    // True when flipping the D index bit changes some entry of the table.
    function automatic logic rop_uses_dst(input logic [7:0] code);
        return (code & 8'h55) != ((code >> 1) & 8'h55);
    endfunction

    // First memory phase of a pixel for a given raster code.
    function automatic blt_state_e first_phase(input logic [7:0] code);
        if (rop_uses_src(code))
            return ST_SRD;
        else if (rop_uses_dst(code))
            return ST_DRD;
        else
            return ST_WR;
    endfunction

endpackage

// File: rtl/blt_rop_alu.sv
// Bitwise raster-operation unit: every output bit looks up the 8-bit
// truth table with its own {P,S,D} bit triple. Purely combinational.
module blt_rop_alu #(
    parameter int DW = 32
) (
    input  logic [7:0]    code,
    input  logic [DW-1:0] pat,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] dst,
    output logic [DW-1:0] res
);
    // One truth-table lookup per bit position.
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign res[i] = code[{pat[i], src[i], dst[i]}];
    end
endmodule

// File: rtl/blt_lane.sv
// Lane aligner: extracts the source pixel from its word lane, moves it and
// the fill colour to the destination lane, and forms the byte strobes.
// Assumes pixels are naturally aligned so one never crosses a word.
module blt_lane
    import blt_pkg::*;
#(
    parameter int DW = 32,
    localparam int NB = DW / 8,
    localparam int LW = $clog2(NB)
) (
    input  logic [1:0]    depth,
    input  logic [LW-1:0] s_lane,
    input  logic [LW-1:0] d_lane,
    input  logic [DW-1:0] s_word,
    input  logic [DW-1:0] fill,
    input  logic          alpha_en,
    input  logic          rgb_en,
    output logic [DW-1:0] s_al,
    output logic [DW-1:0] p_al,
    output logic [NB-1:0] strb
);
    logic [DW-1:0] pix_mask;
    logic [DW-1:0] s_pix;

    // Pixel-width mask, operand alignment and strobe generation.
    always_comb begin
        case (depth)
            DEPTH_1B: pix_mask = DW'(8'hFF);
            DEPTH_2B: pix_mask = DW'(16'hFFFF);
            default:  pix_mask = '1;
        endcase
        s_pix = (s_word >> {s_lane, 3'b000}) & pix_mask;
        s_al  = s_pix << {d_lane, 3'b000};
        p_al  = (fill & pix_mask) << {d_lane, 3'b000};
        case (depth)
            DEPTH_1B: strb = NB'(1) << d_lane;
            DEPTH_2B: strb = NB'(3) << d_lane;
            default:  strb = {alpha_en, {(NB-1){rgb_en}}};
        endcase
    end
endmodule

// File: rtl/blt_walker.sv
// Rectangle walker: computes the first source and destination byte
// addresses once at load, then steps them incrementally, pixel by pixel
// and row by row. Assumes AW <= 2*CW and width/height nonzero at load.
module blt_walker #(
    parameter int AW = 16,
    parameter int CW = 16,
    localparam int PW = 2 * CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] d_base,
    input  logic [CW-1:0] d_pitch,
    input  logic [CW-1:0] d_x,
    input  logic [CW-1:0] d_y,
    input  logic [AW-1:0] s_base,
    input  logic [CW-1:0] s_pitch,
    input  logic [CW-1:0] s_x,
    input  logic [CW-1:0] s_y,
    input  logic [CW-1:0] width,
    input  logic [CW-1:0] height,
    input  logic [1:0]    depth,
    output logic [AW-1:0] d_addr,
    output logic [AW-1:0] s_addr,
    output logic          last
);
    // Signed pitch with the two low bits forced to zero.
    function automatic logic signed [PW-1:0] pitch_ext(input logic [CW-1:0] p);
        return {{CW{p[CW-1]}}, p[CW-1:2], 2'b00};
    endfunction

    logic signed [PW-1:0] d_off, s_off;
    logic [AW-1:0] d_row, s_row, d_cur, s_cur, d_step, s_step, pix_bytes;
    logic [CW-1:0] width_q, col_left, row_left;
    logic [1:0]    depth_q;

    // Start offsets: one multiply per command, taken only at load.
    assign d_off = $signed(d_y) * pitch_ext(d_pitch) + (PW'($signed(d_x)) <<< depth);
    assign s_off = $signed(s_y) * pitch_ext(s_pitch) + (PW'($signed(s_x)) <<< depth);

    assign pix_bytes = AW'(1) << depth_q;

    // Address and counter state: load a command, then advance one pixel per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_row    <= '0;
            s_row    <= '0;
            d_cur    <= '0;
            s_cur    <= '0;
            d_step   <= '0;
            s_step   <= '0;
            width_q  <= '0;
            col_left <= '0;
            row_left <= '0;
            depth_q  <= '0;
        end else if (load) begin
            d_row    <= d_base + AW'(d_off);
            d_cur    <= d_base + AW'(d_off);
            s_row    <= s_base + AW'(s_off);
            s_cur    <= s_base + AW'(s_off);
            d_step   <= AW'(pitch_ext(d_pitch));
            s_step   <= AW'(pitch_ext(s_pitch));
            width_q  <= width;
            col_left <= width;
            row_left <= height;
            depth_q  <= depth;
        end else if (step) begin
            if (col_left == CW'(1)) begin
                d_row    <= d_row + d_step;
                d_cur    <= d_row + d_step;
                s_row    <= s_row + s_step;
                s_cur    <= s_row + s_step;
                col_left <= width_q;
                row_left <= row_left - CW'(1);
            end else begin
                d_cur    <= d_cur + pix_bytes;
                s_cur    <= s_cur + pix_bytes;
                col_left <= col_left - CW'(1);
            end
        end
    end

    assign d_addr = d_cur;
    assign s_addr = s_cur;
    assign last   = (col_left == CW'(1)) && (row_left == CW'(1));

    AST_STEP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (col_left != '0 && row_left != '0)); // R2

endmodule

// File: rtl/blt_engine.sv
// Top of the raster-op blit engine. Accepts a command while not busy,
// then per pixel optionally reads source, optionally reads destination,
// and writes the combined result through a single-beat memory port.
// Assumes bases are aligned to the pixel size so no pixel spans words.
module blt_engine
    import blt_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 32,
    localparam int NB = DW / 8,
    localparam int LW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] dst_base,
    input  logic [CW-1:0] dst_pitch,
    input  logic [CW-1:0] dst_x1,
    input  logic [CW-1:0] dst_y1,
    input  logic [CW-1:0] dst_x2,
    input  logic [CW-1:0] dst_y2,
    input  logic [AW-1:0] src_base,
    input  logic [CW-1:0] src_pitch,
    input  logic [CW-1:0] src_x,
    input  logic [CW-1:0] src_y,
    input  logic [7:0]    rop,
    input  logic [1:0]    depth,
    input  logic [DW-1:0] fill_color,
    input  logic          alpha_en,
    input  logic          rgb_en,
    output logic          busy,
    output logic          done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-LW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic [NB-1:0] mem_wstrb,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);
    blt_state_e    st;
    logic [7:0]    rop_q;
    logic [1:0]    depth_q;
    logic [DW-1:0] fill_q, s_word_q, d_word_q;
    logic          alpha_q, rgb_q;

    logic          accept, cmd_void, last;
    logic [CW-1:0] rect_w, rect_h;
    logic [AW-1:0] d_addr, s_addr;
    logic [DW-1:0] s_al, p_al;

    // Command decode from the ports, valid in the accepting cycle.
    assign rect_w   = dst_x2 - dst_x1;
    assign rect_h   = dst_y2 - dst_y1;
    assign cmd_void = ($signed(dst_x2) <= $signed(dst_x1)) ||
                      ($signed(dst_y2) <= $signed(dst_y1)) ||
                      (depth == 2'd3);
    assign accept   = start && (st == ST_IDLE || st == ST_DONE);

    // Sequencer: per-pixel read/read/write phases and command latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            rop_q    <= '0;
            depth_q  <= '0;
            fill_q   <= '0;
            alpha_q  <= 1'b0;
            rgb_q    <= 1'b0;
            s_word_q <= '0;
            d_word_q <= '0;
        end else begin
            unique case (st)
                ST_IDLE, ST_DONE: begin
                    if (accept) begin
                        rop_q   <= rop;
                        depth_q <= depth;
                        fill_q  <= fill_color;
                        alpha_q <= alpha_en;
                        rgb_q   <= rgb_en;
                        st      <= cmd_void ? ST_DONE : first_phase(rop);
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                ST_SRD: if (mem_ack) begin
                    s_word_q <= mem_rdata;
                    st       <= rop_uses_dst(rop_q) ? ST_DRD : ST_WR;
                end
                ST_DRD: if (mem_ack) begin
                    d_word_q <= mem_rdata;
                    st       <= ST_WR;
                end
                ST_WR: if (mem_ack) begin
                    st <= last ? ST_DONE : first_phase(rop_q);
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    blt_walker #(.AW(AW), .CW(CW)) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept && !cmd_void),
        .step    (st == ST_WR && mem_ack),
        .d_base  (dst_base),
        .d_pitch (dst_pitch),
        .d_x     (dst_x1),
        .d_y     (dst_y1),
        .s_base  (src_base),
        .s_pitch (src_pitch),
        .s_x     (src_x),
        .s_y     (src_y),
        .width   (rect_w),
        .height  (rect_h),
        .depth   (depth),
        .d_addr  (d_addr),
        .s_addr  (s_addr),
        .last    (last)
    );

    blt_lane #(.DW(DW)) u_lane (
        .depth    (depth_q),
        .s_lane   (s_addr[LW-1:0]),
        .d_lane   (d_addr[LW-1:0]),
        .s_word   (s_word_q),
        .fill     (fill_q),
        .alpha_en (alpha_q),
        .rgb_en   (rgb_q),
        .s_al     (s_al),
        .p_al     (p_al),
        .strb     (mem_wstrb)
    );

    blt_rop_alu #(.DW(DW)) u_alu (
        .code (rop_q),
        .pat  (p_al),
        .src  (s_al),
        .dst  (d_word_q),
        .res  (mem_wdata)
    );

    // Port outputs decoded from the sequencer state.
    assign busy     = (st == ST_SRD) || (st == ST_DRD) || (st == ST_WR);
    assign done     = (st == ST_DONE);
    assign mem_req  = busy;
    assign mem_we   = (st == ST_WR);
    assign mem_addr = (st == ST_SRD) ? s_addr[AW-1:LW] : d_addr[AW-1:LW];

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10
    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !cmd_void |=> busy); // R9
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R9
    AST_BYTE_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && depth_q == DEPTH_1B |-> $countones(mem_wstrb) == 1); // R5

endmodule

// File: tb/tb_blt_engine.sv
module tb_blt_engine;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_BYTES  = 4096;
    localparam int SRC_LIMIT  = 2560;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic start = 1'b0;
    logic [15:0] dst_base, dst_pitch, dst_x1, dst_y1, dst_x2, dst_y2;
    logic [15:0] src_base, src_pitch, src_x, src_y;
    logic [7:0]  rop;
    logic [1:0]  depth;
    logic [31:0] fill_color;
    logic        alpha_en, rgb_en;
    logic        busy, done, mem_req, mem_we;
    logic [13:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_wstrb;
    logic        mem_ack;
    logic [31:0] mem_rdata;

    blt_engine dut (.*);

    typedef struct {
        int dbase; int dp; int x1; int y1; int x2; int y2;
        int sbase; int sp; int sx; int sy;
        int code; int dep; logic [31:0] fill; bit a_en; bit r_en;
    } cmd_t;

    logic [7:0] mem [MEM_BYTES];
    logic [7:0] exp_mem [MEM_BYTES];
    int total = 0, bad = 0;
    int srd_cnt, drd_cnt, wr_cnt, done_cnt, ord_idx;
    cmd_t cur;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic bit uses_s(input int code);
        for (int i = 0; i < 8; i++) if (code[i] != code[i ^ 2]) return 1;
        return 0;
    endfunction

    function automatic bit uses_d(input int code);
        for (int i = 0; i < 8; i++) if (code[i] != code[i ^ 1]) return 1;
        return 0;
    endfunction

    function automatic int npix(input cmd_t c);
        if (c.dep == 3 || c.x2 <= c.x1 || c.y2 <= c.y1) return 0;
        return (c.x2 - c.x1) * (c.y2 - c.y1);
    endfunction

    // Expected pixel address for write number k of command c (R3, R8).
    function automatic int pix_addr(input cmd_t c, input int k);
        int w = c.x2 - c.x1;
        return c.dbase + (c.y1 + k / w) * (c.dp & ~3) + (c.x1 + k % w) * (1 << c.dep);
    endfunction

    // Reference model of one command applied to exp_mem (R1..R6).
    task automatic golden(input cmd_t c);
        int bpp, da, sa;
        logic [7:0] pb, sb, db, rb;
        bit en;
        if (npix(c) == 0) return;
        bpp = 1 << c.dep;
        for (int r = 0; r < c.y2 - c.y1; r++) begin
            for (int x = 0; x < c.x2 - c.x1; x++) begin
                da = c.dbase + (c.y1 + r) * (c.dp & ~3) + (c.x1 + x) * bpp;
                sa = c.sbase + (c.sy + r) * (c.sp & ~3) + (c.sx + x) * bpp;
                for (int b = 0; b < bpp; b++) begin
                    pb = c.fill[8*b +: 8];
                    sb = exp_mem[(sa + b) & 'hFFF];
                    db = exp_mem[(da + b) & 'hFFF];
                    for (int k = 0; k < 8; k++) rb[k] = c.code[{pb[k], sb[k], db[k]}];
                    en = (bpp == 4) ? ((b == 3) ? c.a_en : c.r_en) : 1'b1;
                    if (en) exp_mem[(da + b) & 'hFFF] = rb;
                end
            end
        end
    endtask

    task automatic drive(input cmd_t c);
        dst_base = 16'(c.dbase); dst_pitch = 16'(c.dp);
        dst_x1 = 16'(c.x1); dst_y1 = 16'(c.y1); dst_x2 = 16'(c.x2); dst_y2 = 16'(c.y2);
        src_base = 16'(c.sbase); src_pitch = 16'(c.sp);
        src_x = 16'(c.sx); src_y = 16'(c.sy);
        rop = 8'(c.code); depth = 2'(c.dep); fill_color = c.fill;
        alpha_en = c.a_en; rgb_en = c.r_en;
    endtask

    // Memory model: random stalls, write-order check, read accounting.
    initial begin
        int ba, ea;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (done) done_cnt++;
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req && ($urandom % 4 != 0)) begin
                ba = {mem_addr, 2'b00} & 'hFFF;
                if (mem_we) begin
                    ea = pix_addr(cur, ord_idx);
                    check(mem_addr == 14'((ea & 'hFFFF) >> 2), "R8", "write word order",
                          mem_addr, (ea & 'hFFFF) >> 2);
                    ord_idx++;
                    for (int b = 0; b < 4; b++) if (mem_wstrb[b]) mem[ba + b] = mem_wdata[8*b +: 8];
                    wr_cnt++;
                end else begin
                    mem_rdata = {mem[ba+3], mem[ba+2], mem[ba+1], mem[ba]};
                    if (ba < SRC_LIMIT) srd_cnt++; else drd_cnt++;
                end
                mem_ack = 1'b1;
            end
        end
    end

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic clear_counts(input cmd_t c);
        srd_cnt = 0; drd_cnt = 0; wr_cnt = 0; done_cnt = 0; ord_idx = 0; cur = c;
    endtask

    task automatic compare_image(input string req);
        int nbad = 0, first = -1;
        for (int i = 0; i < MEM_BYTES; i++)
            if (mem[i] !== exp_mem[i]) begin nbad++; if (first < 0) first = i; end
        if (first < 0) check(1'b1, req, "memory image", 0, 0);
        else check(1'b0, req, $sformatf("memory image byte %0d", first), mem[first], exp_mem[first]);
    endtask

    task automatic run_cmd(input cmd_t c, input string req);
        exp_mem = mem;
        golden(c);
        @(negedge clk);
        clear_counts(c);
        drive(c);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        @(negedge clk);
        compare_image(req);
        check(wr_cnt == npix(c), "R7", "write count", wr_cnt, npix(c));
        check(srd_cnt == npix(c) * uses_s(c.code), "R7", "source reads", srd_cnt, npix(c) * uses_s(c.code));
        check(drd_cnt == npix(c) * uses_d(c.code), "R7", "dest reads", drd_cnt, npix(c) * uses_d(c.code));
        check(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
    endtask

    function automatic cmd_t base_cmd(input int code, input int dep);
        cmd_t c;
        c.dbase = 2560; c.dp = 64; c.x1 = 1; c.y1 = 1; c.x2 = 5; c.y2 = 4;
        c.sbase = 1200; c.sp = 64; c.sx = 2; c.sy = 0;
        c.code = code; c.dep = dep; c.fill = 32'hA5C3_1E7F; c.a_en = 1; c.r_en = 1;
        return c;
    endfunction

    function automatic cmd_t rand_cmd();
        cmd_t c;
        int spm;
        c.dep = $urandom % 3;
        c.dp = (($urandom % 2) ? 128 : 64) + ($urandom % 4);
        c.x1 = $urandom % 8; c.x2 = c.x1 + 1 + $urandom % 8;
        c.y1 = $urandom % 4; c.y2 = c.y1 + 1 + $urandom % 6;
        c.dbase = 2560 + 4 * ($urandom % 64);
        c.sbase = 1200 + 4 * ($urandom % 16);
        spm = ($urandom % 2) ? 128 : 64;
        c.sp = (($urandom % 2) ? -spm : spm) + ($urandom % 4);
        c.sx = $urandom % 8; c.sy = $urandom % 4;
        c.code = $urandom % 256; c.fill = $urandom;
        c.a_en = $urandom % 2; c.r_en = $urandom % 2;
        return c;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R9", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cmd_t a, b;
        int na;
        void'($urandom(32'd2024));
        for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'($urandom);
        drive(base_cmd(8'hCC, 2));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R9", "busy after reset", busy, 0);
        check(done == 1'b0, "R9", "done after reset", done, 0);
        check(mem_req == 1'b0, "R9", "mem_req after reset", mem_req, 0);

        // R1 copy, 4-byte pixels, pitch low bits ignored (R3)
        a = base_cmd(8'hCC, 2); a.dp = 67; a.sp = 66; run_cmd(a, "R3");
        // R1 xor on 1-byte pixels at odd lanes
        a = base_cmd(8'h66, 0); a.x1 = 3; a.x2 = 10; a.sx = 5; run_cmd(a, "R1");
        // R1 invert destination on 2-byte pixels, D reads only
        a = base_cmd(8'h55, 1); run_cmd(a, "R1");
        // R1 clear, set, fill, pass-through
        run_cmd(base_cmd(8'h00, 2), "R1");
        run_cmd(base_cmd(8'hFF, 0), "R1");
        run_cmd(base_cmd(8'hF0, 1), "R1");
        run_cmd(base_cmd(8'hAA, 2), "R1");
        // R6 alpha-only opaque fill
        a = base_cmd(8'hF0, 2); a.fill = 32'hFFFF_FFFF; a.a_en = 1; a.r_en = 0; run_cmd(a, "R6");
        // R6 enables ignored for 2-byte pixels
        a = base_cmd(8'hCC, 1); a.a_en = 0; a.r_en = 0; run_cmd(a, "R6");
        // R2 empty rectangles
        a = base_cmd(8'hFF, 2); a.x2 = a.x1; run_cmd(a, "R2");
        a = base_cmd(8'hFF, 2); a.y2 = a.y1 - 1; run_cmd(a, "R2");
        // R5 depth code 3 writes nothing
        run_cmd(base_cmd(8'hFF, 3), "R5");
        // R4 negative source pitch flips rows
        a = base_cmd(8'hCC, 2); a.sbase = 1400; a.sp = -64; a.sy = 3; a.y1 = 0; a.y2 = 4; run_cmd(a, "R4");

        // R9 start during a walk is ignored
        a = base_cmd(8'h66, 2); a.x1 = 0; a.x2 = 8; a.y1 = 0; a.y2 = 6;
        b = base_cmd(8'h00, 2); b.x1 = 0; b.x2 = 12; b.y1 = 0; b.y2 = 10;
        exp_mem = mem; golden(a);
        @(negedge clk); clear_counts(a); drive(a); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R9", "busy during walk", busy, 1);
        drive(b); start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done(); @(negedge clk);
        compare_image("R9");
        check(done_cnt == 1, "R9", "done pulses with ignored start", done_cnt, 1);
        check(wr_cnt == npix(a), "R9", "writes with ignored start", wr_cnt, npix(a));

        // R9 new command accepted in the done cycle
        a = base_cmd(8'hCC, 0); b = base_cmd(8'h99, 1); b.dbase = 3000;
        exp_mem = mem; golden(a); golden(b);
        @(negedge clk); clear_counts(a); drive(a); start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
        na = wr_cnt; cur = b; ord_idx = 0; drive(b); start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done(); @(negedge clk);
        compare_image("R9");
        check(done_cnt == 2, "R9", "done pulses back to back", done_cnt, 2);
        check(na + (wr_cnt - na) == npix(a) + npix(b), "R7", "writes back to back", wr_cnt, npix(a) + npix(b));

        // random commands
        for (int n = 0; n < 30; n++) run_cmd(rand_cmd(), "R1");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule